// File: doc/BRIEF.md
# Debug-Haltable Timer Prescaler

This block is the counting core of a general-purpose timer. It holds an 8-bit free-running prescaler whose bits act as divide-by-2 up to divide-by-256 taps. It also holds a pulse accumulator that counts rising edges on input pin 0, and a bank of two-stage input synchronizers. The edge detector on the highest pin raises an input-capture flag. A small control register sets whether the counting runs. It can shut everything off (low-power stop), freeze it for an external debugger, or halt it so that software can step it one count at a time.

Software reaches four registers through a plain read/write port. The read data is combinational from the address. While the debug freeze is in force, the accumulator (read-only otherwise) can be written, and the write-once capture configuration can be rewritten any number of times. An edge that the detector has already seen when freeze begins still completes its capture. The three modes have a fixed priority: stop first, then freeze, then single-step halt.

Top module: `tmr_dbg_prescaler`

## Requirements
- R1: After reset, the prescaler, accumulator, synchronized pins, capture flag, capture configuration and control register (address 0) all read zero.
- R2: With the stop, active-freeze and halt conditions all false, the prescaler advances by one on every clock and wraps modulo 256.
- R3: While control bit 0 (stop) is set, the prescaler, accumulator and synchronizers hold. Stop overrides freeze and halt, and a step request made during stop is dropped.
- R4: Freeze is active only when the freeze request input is high and control bit 1 is set. Control bit 2 is stored and read back but has no effect on counting.
- R5: During active freeze, the prescaler and accumulator hold and the synchronizers are not clocked, so pin changes do not reach the pin outputs. Freeze ends when the request falls or when control bit 1 is cleared.
- R6: Address 1 reads the accumulator. A write to address 1 loads it only during active freeze and is ignored otherwise.
- R7: Address 3 holds the capture polarity in bit 0 (0 = rising, 1 = falling) and a lock flag in bit 1. Outside freeze only the first write after reset takes effect and sets the lock. During freeze, writes always take effect.
- R8: An edge that the detector has already seen in the cycle when freeze becomes active still sets the capture flag.
- R9: While control bit 3 (halt) is set and no step is pending, the prescaler does not advance and the synchronized pin outputs keep the values they had when the halt began.
- R10: Writing a 1 to control bit 4 (step) while halted advances the prescaler by exactly one and clocks the synchronizers once, so two steps carry a pin change to the outputs. The step bit reads 1 for one cycle and then clears itself.
- R11: A step request when halt is clear, or during stop or freeze, has no effect beyond clearing itself one cycle later.
- R12: The accumulator increments once per rising edge of pin 0. It changes three clocks after the pin rises, in running mode.
- R13: The capture flag is set by the selected edge on the highest pin, three clocks after the pin changes, and is read at address 2 bit 7. Writing 1 to address 2 bit 7 clears it. Address 2 bits [1:0] read the synchronized pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dbg_frz_req | input | 1 | Freeze request from the debug controller |
| pin_in | input | NPIN | Asynchronous input pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| presc_tap | output | PRESC_W | Prescaler count; bit k is the divide-by-2^(k+1) tap |
| acc_count | output | ACC_W | Pulse accumulator count |
| pin_sync | output | NPIN | Synchronized pin values |
| cap_flag | output | 1 | Input-capture flag |

## Verification
The hardest case to reach is the capture that completes across the start of a freeze. The pin edge must have just passed the second synchronizer stage in the very cycle when the freeze request and the enable bit first combine. The stimulus drives the pin, waits exactly two clocks, and then raises the freeze request. A step request landing during stop, with the halt bit also set, is built by a direct register write. The bench then checks that the count stays put after stop is lifted. Random register traffic and pin activity, compared every cycle against a bench reference model, cover the remaining mode overlaps.

// File: rtl/tmr_dbg_pkg.sv
package tmr_dbg_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ACC  = 2'd1,
    REG_STAT = 2'd2,
    REG_CFG  = 2'd3
  } reg_sel_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic step;
    logic hold;
    logic frz_hi;
    logic frz_lo;
    logic stop;
  } mode_ctl_t;

  localparam int CTL_W = 5;

endpackage

// File: rtl/tmr_mode_ctl.sv
module tmr_mode_ctl
  import tmr_dbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frz_req,
  input  logic             wr_ctl,
  input  logic [CTL_W-1:0] wr_val,
  output mode_ctl_t        ctl,
  output logic             frz_act,
  output logic             tick
);

  mode_ctl_t ctl_d;

  // step lives for one cycle unless rewritten
  always_comb begin
    ctl_d      = ctl;
    ctl_d.step = 1'b0;
    if (wr_ctl) ctl_d = mode_ctl_t'(wr_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_d;
  end

  // priority: stop > freeze > halt/step
  assign frz_act = frz_req & ctl.frz_lo & ~ctl.stop;
  assign tick    = ~ctl.stop & ~frz_act & (~ctl.hold | ctl.step);

endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NPIN-1:0] pins,
  output logic [NPIN-1:0] stage2,
  output logic [NPIN-1:0] prev,
  output logic            fresh
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic st1, st2, pv;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
        pv  <= 1'b0;
      end else if (tick) begin
        st1 <= pins[i];
        st2 <= st1;
        pv  <= st2;
      end
    end
    assign stage2[i] = st2;
    assign prev[i]   = pv;
  end

  // marks the cycle right after the synchronizers moved
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh <= 1'b0;
    else        fresh <= tick;
  end

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int PRESC_W = 8,
  parameter int ACC_W   = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               cnt_ok,
  input  logic               frz_act,
  input  logic               acc_inc,
  input  logic               cap_set,
  input  logic               wr_acc,
  input  logic               wr_stat,
  input  logic               wr_cfg,
  input  logic [DATA_W-1:0]  wdata,
  output logic [PRESC_W-1:0] presc,
  output logic [ACC_W-1:0]   acc,
  output logic               cap_flag,
  output logic               cap_pol,
  output logic               cfg_lock
);

  logic [PRESC_W-1:0] presc_d;
  logic [ACC_W-1:0]   acc_d;
  logic               cap_d, pol_d, lock_d;

  always_comb begin
    presc_d = presc;
    if (tick) presc_d = presc + PRESC_W'(1);

    acc_d = acc;
    if (wr_acc && frz_act)       acc_d = wdata[ACC_W-1:0];
    else if (acc_inc && cnt_ok)  acc_d = acc + ACC_W'(1);

    cap_d = cap_flag;
    if (cap_set)                        cap_d = 1'b1;
    else if (wr_stat && wdata[DATA_W-1]) cap_d = 1'b0;

    pol_d  = cap_pol;
    lock_d = cfg_lock;
    if (wr_cfg && (!cfg_lock || frz_act)) begin
      pol_d  = wdata[0];
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc    <= '0;
      acc      <= '0;
      cap_flag <= 1'b0;
      cap_pol  <= 1'b0;
      cfg_lock <= 1'b0;
    end else begin
      presc    <= presc_d;
      acc      <= acc_d;
      cap_flag <= cap_d;
      cap_pol  <= pol_d;
      cfg_lock <= lock_d;
    end
  end

endmodule

// File: rtl/tmr_dbg_prescaler.sv
module tmr_dbg_prescaler
  import tmr_dbg_pkg::*;
#(
  parameter int NPIN    = 2,
  parameter int PRESC_W = 8,
  parameter int ACC_W   = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbg_frz_req,
  input  logic [NPIN-1:0]    pin_in,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [PRESC_W-1:0] presc_tap,
  output logic [ACC_W-1:0]   acc_count,
  output logic [NPIN-1:0]    pin_sync,
  output logic               cap_flag
);

  localparam int CAP_PIN = NPIN - 1;

  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic wr_ctl, wr_acc, wr_stat, wr_cfg;
  assign wr_ctl  = reg_wr && (reg_addr == 2'(REG_CTRL));
  assign wr_acc  = reg_wr && (reg_addr == 2'(REG_ACC));
  assign wr_stat = reg_wr && (reg_addr == 2'(REG_STAT));
  assign wr_cfg  = reg_wr && (reg_addr == 2'(REG_CFG));

  mode_ctl_t ctl;
  logic      frz_act, tick;
  logic      stop_b, hold_b, step_b;

  tmr_mode_ctl u_mode (
    .clk     (clk),
    .rst_n   (rst_q),
    .frz_req (dbg_frz_req),
    .wr_ctl  (wr_ctl),
    .wr_val  (reg_wdata[CTL_W-1:0]),
    .ctl     (ctl),
    .frz_act (frz_act),
    .tick    (tick)
  );

  assign stop_b = ctl.stop;
  assign hold_b = ctl.hold;
  assign step_b = ctl.step;

  logic [NPIN-1:0] prev;
  logic            fresh;

  tmr_pin_sync #(.NPIN(NPIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q),
    .tick   (tick),
    .pins   (pin_in),
    .stage2 (pin_sync),
    .prev   (prev),
    .fresh  (fresh)
  );

  logic cap_pol, cfg_lock, acc_inc, cap_set, cnt_ok;
  assign acc_inc = fresh & pin_sync[0] & ~prev[0];
  assign cap_set = fresh & (pin_sync[CAP_PIN] ^ prev[CAP_PIN])
                 & (pin_sync[CAP_PIN] ^ cap_pol);
  assign cnt_ok  = ~stop_b & ~frz_act;

  tmr_count_unit #(.PRESC_W(PRESC_W), .ACC_W(ACC_W), .DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q),
    .tick     (tick),
    .cnt_ok   (cnt_ok),
    .frz_act  (frz_act),
    .acc_inc  (acc_inc),
    .cap_set  (cap_set),
    .wr_acc   (wr_acc),
    .wr_stat  (wr_stat),
    .wr_cfg   (wr_cfg),
    .wdata    (reg_wdata),
    .presc    (presc_tap),
    .acc      (acc_count),
    .cap_flag (cap_flag),
    .cap_pol  (cap_pol),
    .cfg_lock (cfg_lock)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'(REG_CTRL): reg_rdata[CTL_W-1:0] = ctl;
      2'(REG_ACC):  reg_rdata = DATA_W'(acc_count);
      2'(REG_STAT): begin
        reg_rdata[DATA_W-1] = cap_flag;
        reg_rdata[NPIN-1:0] = pin_sync;
      end
      default:      reg_rdata[1:0] = {cfg_lock, cap_pol};
    endcase
  end

endmodule

// File: rtl/tmr_dbg_checker.sv
module tmr_dbg_checker #(
  parameter int NPIN    = 2,
  parameter int PRESC_W = 8,
  parameter int ACC_W   = 8,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               stop_b,
  input logic               hold_b,
  input logic               step_b,
  input logic               frz_act,
  input logic               reg_wr,
  input logic [1:0]         reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [PRESC_W-1:0] presc,
  input logic [ACC_W-1:0]   acc,
  input logic [NPIN-1:0]    pins
);

  a_r2_run_counts: assert property (@(posedge clk) disable iff (!rst_ok)
    (!stop_b && !hold_b && !frz_act) |=> presc == PRESC_W'($past(presc) + 1'b1));

  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    stop_b |=> (presc == $past(presc)) && (acc == $past(acc)) && (pins == $past(pins)));

  a_r5_freeze_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    frz_act |=> (presc == $past(presc)) && (pins == $past(pins)));

  a_r9_halt_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    (hold_b && !step_b) |=> (presc == $past(presc)) && (pins == $past(pins)));

  a_r10_step_once: assert property (@(posedge clk) disable iff (!rst_ok)
    (hold_b && step_b && !stop_b && !frz_act) |=> presc == PRESC_W'($past(presc) + 1'b1));

  a_r10_step_clears: assert property (@(posedge clk) disable iff (!rst_ok)
    (step_b && !(reg_wr && reg_addr == 2'd0 && reg_wdata[4])) |=> !step_b);

endmodule

bind tmr_dbg_prescaler tmr_dbg_checker #(
  .NPIN(NPIN), .PRESC_W(PRESC_W), .ACC_W(ACC_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_q),
  .stop_b    (stop_b),
  .hold_b    (hold_b),
  .step_b    (step_b),
  .frz_act   (frz_act),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .presc     (presc_tap),
  .acc       (acc_count),
  .pins      (pin_sync)
);

// File: tb/sim_tmr_dbg_prescaler.sv
module sim_tmr_dbg_prescaler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dbg_frz_req = 1'b0;
  logic [1:0] pin_in = 2'b00;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, presc_tap, acc_count;
  logic [1:0] pin_sync;
  logic       cap_flag;

  always #10 clk = ~clk;

  tmr_dbg_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .dbg_frz_req(dbg_frz_req), .pin_in(pin_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .presc_tap(presc_tap), .acc_count(acc_count),
    .pin_sync(pin_sync), .cap_flag(cap_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0] m_rs;
  logic m_stop, m_f0, m_f1, m_hold, m_step;
  logic [7:0] m_presc, m_acc;
  logic [1:0] m_s1, m_s2, m_prev;
  logic m_fresh, m_cap, m_pol, m_lock;

  task automatic m_clear();
    {m_stop, m_f0, m_f1, m_hold, m_step} = '0;
    m_presc = '0; m_acc = '0;
    m_s1 = '0; m_s2 = '0; m_prev = '0;
    m_fresh = 0; m_cap = 0; m_pol = 0; m_lock = 0;
  endtask

  task automatic m_advance();
    logic frz, run, tk, up0, ce;
    frz = dbg_frz_req & m_f0 & !m_stop;
    run = !m_stop & !frz;
    tk  = run & (!m_hold | m_step);
    up0 = m_fresh & m_s2[0] & !m_prev[0];
    ce  = m_fresh & (m_s2[1] != m_prev[1]) & (m_pol ? !m_s2[1] : m_s2[1]);
    if (reg_wr && reg_addr == 2'd1 && frz) m_acc = reg_wdata;
    else if (up0 && run)                   m_acc = m_acc + 8'd1;
    if (ce) m_cap = 1;
    else if (reg_wr && reg_addr == 2'd2 && reg_wdata[7]) m_cap = 0;
    if (reg_wr && reg_addr == 2'd3 && (!m_lock || frz)) begin
      m_pol = reg_wdata[0]; m_lock = 1;
    end
    if (tk) begin
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in; m_presc = m_presc + 8'd1;
    end
    m_fresh = tk;
    if (reg_wr && reg_addr == 2'd0) {m_step, m_hold, m_f1, m_f0, m_stop} = reg_wdata[4:0];
    else m_step = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 2'b00; m_clear();
    end else begin
      logic ok;
      ok = m_rs[1];
      m_rs = {m_rs[0], 1'b1};
      if (!ok) m_clear(); else m_advance();
    end
  end

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {3'b000, m_step, m_hold, m_f1, m_f0, m_stop};
      2'd1:    return m_acc;
      2'd2:    return {m_cap, 5'b0, m_s2};
      default: return {6'b0, m_lock, m_pol};
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 prescaler vs model", presc_tap, m_presc);
      chk("R12 accumulator vs model", acc_count, m_acc);
      chk("R9 pin_sync vs model", pin_sync, m_s2);
      chk("R13 cap_flag vs model", cap_flag, m_cap);
      chk("R6 reg_rdata vs model", reg_rdata, exp_rd(reg_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick_n(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick_n(1);
    reg_wr = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] p, p2, a;
    logic [1:0] ps;
    void'($urandom(32'd20240611));
    tick_n(3);
    rst_n = 1;
    cmp_on = 1;
    tick_n(2);

    // R1
    chk("R1 prescaler reset", presc_tap, 8'h00);
    chk("R1 accumulator reset", acc_count, 8'h00);
    chk("R1 cap_flag reset", cap_flag, 1'b0);
    chk("R1 pin_sync reset", pin_sync, 2'b00);
    chk("R1 ctrl reset", reg_rdata, 8'h00);

    // R2
    p = presc_tap; tick_n(5);
    chk("R2 five counts", presc_tap, 8'(p + 5));

    // R12 latency
    a = acc_count; pin_in[0] = 1;
    tick_n(2); chk("R12 no count yet", acc_count, a);
    tick_n(1); chk("R12 counted rise", acc_count, 8'(a + 1));
    pin_in[0] = 0; tick_n(4);

    // R13 capture and clear
    pin_in[1] = 1; tick_n(3);
    chk("R13 capture on rise", cap_flag, 1'b1);
    wr(2'd2, 8'h80);
    chk("R13 write-1 clears", cap_flag, 1'b0);
    pin_in[1] = 0; tick_n(4);
    chk("R13 falling ignored", cap_flag, 1'b0);

    // R7 write-once
    wr(2'd3, 8'h01); chk("R7 first cfg write", reg_rdata, 8'h03);
    wr(2'd3, 8'h00); chk("R7 locked cfg", reg_rdata, 8'h03);

    // R4 upper freeze bit inert
    wr(2'd0, 8'h04); dbg_frz_req = 1;
    p = presc_tap; tick_n(3);
    chk("R4 upper bit no freeze", presc_tap, 8'(p + 3));

    // R5 / R6 / R7 in freeze
    wr(2'd0, 8'h02);
    p = presc_tap; ps = pin_sync; pin_in = 2'b11;
    tick_n(4);
    chk("R5 prescaler frozen", presc_tap, p);
    chk("R5 pins ignored", pin_sync, ps);
    wr(2'd1, 8'h5A); chk("R6 acc write in freeze", acc_count, 8'h5A);
    wr(2'd3, 8'h00); chk("R7 cfg rewrite in freeze", reg_rdata, 8'h02);
    pin_in = 2'b00;
    dbg_frz_req = 0;
    p = presc_tap; tick_n(2);
    chk("R5 freeze ends on request drop", presc_tap, 8'(p + 2));
    tick_n(4);
    a = acc_count; wr(2'd1, 8'h11);
    chk("R6 acc read-only outside freeze", acc_count, a);

    // R8 edge at freeze onset
    wr(2'd0, 8'h02);
    pin_in[1] = 1; tick_n(2);
    dbg_frz_req = 1; tick_n(1);
    chk("R8 capture completes at freeze", cap_flag, 1'b1);
    p = presc_tap; tick_n(2);
    chk("R5 frozen after capture", presc_tap, p);
    wr(2'd0, 8'h00);
    p = presc_tap; tick_n(2);
    chk("R5 freeze ends on enable clear", presc_tap, 8'(p + 2));
    dbg_frz_req = 0; wr(2'd2, 8'h80);
    pin_in = 2'b00; tick_n(4);

    // R3 stop and priority
    wr(2'd0, 8'h01);
    p = presc_tap; ps = pin_sync; pin_in = 2'b01;
    tick_n(4);
    chk("R3 stop holds prescaler", presc_tap, p);
    chk("R3 stop holds pins", pin_sync, ps);
    dbg_frz_req = 1;
    wr(2'd0, 8'h1B);
    tick_n(1);
    chk("R11 step dropped in stop", reg_rdata, 8'h0B);
    chk("R3 stop beats step", presc_tap, p);
    dbg_frz_req = 0;
    wr(2'd0, 8'h08);
    p2 = presc_tap; tick_n(3);
    chk("R11 dropped step no count", presc_tap, p2);

    // R9 / R10
    ps = pin_sync; pin_in = 2'b10; tick_n(3);
    chk("R9 halted pins held", pin_sync, ps);
    wr(2'd0, 8'h18);
    chk("R10 step bit visible", reg_rdata, 8'h18);
    chk("R10 no count before step edge", presc_tap, p2);
    tick_n(1);
    chk("R10 one step count", presc_tap, 8'(p2 + 1));
    chk("R10 step self-clears", reg_rdata, 8'h08);
    chk("R10 one sync clock only", pin_sync, ps);
    wr(2'd0, 8'h18); tick_n(1);
    chk("R10 second step count", presc_tap, 8'(p2 + 2));
    chk("R10 two steps reach pins", pin_sync, 2'b10);

    // R11 step without halt
    wr(2'd0, 8'h10); tick_n(1);
    chk("R11 step clears when not halted", reg_rdata, 8'h00);
    p = presc_tap; tick_n(2);
    chk("R11 normal rate only", presc_tap, 8'(p + 2));

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      if ($urandom % 4 == 0) pin_in = 2'($urandom);
      if ($urandom % 16 == 0) dbg_frz_req = ~dbg_frz_req;
      reg_addr = 2'($urandom);
      d = 8'($urandom);
      if (reg_addr == 2'd0 && ($urandom % 8 != 0)) d[0] = 1'b0;
      if (reg_addr == 2'd0 && ($urandom % 3 != 0)) d[3] = 1'b0;
      reg_wdata = d;
      reg_wr = ($urandom % 4 == 0);
      tick_n(1);
    end
    reg_wr = 0;
    tick_n(2);

    done = 1;
    summary();
    $finish;
  end

endmodule